// File: doc/BRIEF.md
# ALU Operation Control Decoder

This block produces the control word for a 32-bit ALU in a sequenced processor core. Each cycle it takes a 3-bit micro-command from the instruction sequencer, the 4-bit data-processing opcode field of the current instruction, a trap/abort input and the current carry flag. From these it works out which ALU function to run, whether the carry chain is enabled, and what carries into bit 0. It also drives three side flags:

- a compare-class indicator, active low;
- a status-register update enable;
- an arithmetic-versus-logical indicator. This one tells the flag logic whether carry comes from the ALU or from the shifter, and whether overflow is updated.

Internally, a decoder raises exactly one of 31 rows. Sixteen rows serve the programmer-visible opcodes. Fifteen serve hidden micro-operations that borrow the ALU for address arithmetic, branch targets and load sequencing. Some of these hidden rows run ADD or RSB with a carry-in that the plain opcode would not use. An OR-plane ROM turns the active row into a control word. A carry stage then passes the carry flag through, or forces the carry-in low or high. Every output is registered and appears one clock after the inputs that produce it.

Top module: `alu_ctl`

## Requirements
- R1: With micro-command 3'b111, `alu_fn_o` equals the opcode input one cycle later. The function code uses the data-processing opcode values: AND 0000, EOR 0001, SUB 0010, RSB 0011, ADD 0100, ADC 0101, SBC 0110, RSC 0111, TST 1000, TEQ 1001, CMP 1010, CMN 1011, ORR 1100, MOV 1101, BIC 1110, MVN 1111.
- R2: Every one of the 512 combinations of micro-command, opcode, trap and carry flag selects exactly one of 31 rows. The registered outputs match the row described by R1, R3, R5 to R9 and R12.
- R3: For micro-command 3'b111, the carry-in is:
  - 0 for ADD and CMN;
  - 1 for SUB, RSB and CMP;
  - the carry flag for ADC, SBC and RSC.
- R4: The carry flag is sampled at the same clock edge as the command that uses it. A change in the flag after that edge does not alter the carry-in being presented.
- R5: Under micro-command 3'b111, `not_cmp_o` is 0 exactly for opcodes 1000 to 1011. It is 1 for the other twelve opcodes and for every internal row.
- R6: `psr_we_o` is 1 for every micro-command 3'b111 row and 0 for every other micro-command.
- R7: `arith_o` is 1 only under micro-command 3'b111 with opcode 0010 to 0111, 1010 or 1011.
- R8: When the carry chain enable is 0, the carry-in output is 0 whatever the carry flag is. Logical opcodes have the chain disabled.
- R9: The internal rows have `psr_we_o`=0, `arith_o`=0 and `not_cmp_o`=1. Their function, chain enable and carry-in are:
  - 001: opcode bit 2 = 0 gives ADD with cin 0; bit 2 = 1 gives SUB with cin 1.
  - 010: opcode bit 0 = 0 gives ADD with cin 1; bit 0 = 1 gives RSB with cin 0.
  - 011: MOV with the chain enabled and cin 1.
  - 100: opcode bit 2 = 0 gives SUB with cin 1; bit 2 = 1 gives ADD with cin 0.
  - 101 without trap: opcode bit 2 = 0 gives SUB with cin 1; bit 2 = 1 gives ADD with cin 0.
  - 101 with trap: MOV with the chain off.
  - 110 without trap: ADD with cin 0.
  - 110 with trap: RSB with cin 1.
- R10: The trap input changes the outputs only for micro-commands 3'b101 and 3'b110.
- R11: While reset is high, and on the cycle after it, the outputs hold the no-op word: fn 1101, chain 0, cin 0, not_cmp 1, psr_we 0, arith 0.
- R12: Micro-command 3'b000 with opcode 0100 gives ADD with the chain on and cin 0. With any other opcode it gives MOV with the chain off and the status update off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ucmd_i | input | 3 | Micro-command from the sequencer |
| opcode_i | input | 4 | Data-processing opcode field |
| trap_i | input | 1 | Trap/abort indication from the load sequencing |
| carry_i | input | 1 | Current carry flag |
| alu_fn_o | output | 4 | ALU function select |
| chain_en_o | output | 1 | Carry chain enable |
| carry_in_o | output | 1 | Carry into ALU bit 0 |
| not_cmp_o | output | 1 | Low for compare/test opcodes |
| psr_we_o | output | 1 | Status flag update enable |
| arith_o | output | 1 | High for arithmetic opcodes |

## Verification
Several properties are checked on every cycle:
- the row decoder raises a single row;
- a pass-through carry-in equals the flag sampled one edge earlier;
- the opcode reappears as the function under the data-processing command;
- internal commands never enable the status update;
- compare opcodes pull the compare indicator low;
- a disabled chain never carries a 1 in.

The exact row content is left to the bench. This covers the forced carry values of the hidden ADD and RSB variants, the trap redirection of the load rows, and the no-op default. The bench shows these by sweeping all 512 input combinations against an independent model, and by directed tests of late carry changes and of reset.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;
  localparam int N_INT_ROWS = 15;
  localparam int N_DP_ROWS  = 16;
  localparam int N_ROWS     = N_INT_ROWS + N_DP_ROWS;

  typedef enum logic [1:0] {CM_ZERO = 2'd0, CM_ONE = 2'd1, CM_PASS = 2'd2} cmode_e;

  typedef struct packed {
    logic [3:0] fn;
    logic       chain;
    cmode_e     cmode;
    logic       cmp_n;
    logic       psr;
    logic       arith;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [3:0] OP_SUB = 4'b0010;
  localparam logic [3:0] OP_RSB = 4'b0011;
  localparam logic [3:0] OP_ADD = 4'b0100;
  localparam logic [3:0] OP_MOV = 4'b1101;

  function automatic ctl_t mk_int(logic [3:0] fn, logic chain, cmode_e cm);
    ctl_t w;
    w.fn = fn; w.chain = chain; w.cmode = cm;
    w.cmp_n = 1'b1; w.psr = 1'b0; w.arith = 1'b0;
    return w;
  endfunction

  // Control word for decode row r; rows at and above N_INT_ROWS are opcodes.
  function automatic ctl_t row_word(int r);
    ctl_t w;
    logic [3:0] op;
    if (r >= N_INT_ROWS) begin
      op      = 4'(r - N_INT_ROWS);
      w.fn    = op;
      w.psr   = 1'b1;
      w.cmp_n = (op[3:2] != 2'b10);
      w.arith = (op inside {[4'd2:4'd7], 4'd10, 4'd11});
      w.chain = w.arith;
      case (op)
        4'd2, 4'd3, 4'd10:  w.cmode = CM_ONE;
        4'd5, 4'd6, 4'd7:   w.cmode = CM_PASS;
        default:            w.cmode = CM_ZERO;
      endcase
    end else begin
      case (r)
        0, 2, 9, 12, 14: w = mk_int(OP_ADD, 1'b1, CM_ZERO);
        3, 8, 11:        w = mk_int(OP_SUB, 1'b1, CM_ONE);
        4:               w = mk_int(OP_ADD, 1'b1, CM_ONE);
        5:               w = mk_int(OP_RSB, 1'b1, CM_ZERO);
        6, 7:            w = mk_int(OP_MOV, 1'b1, CM_ONE);
        13:              w = mk_int(OP_RSB, 1'b1, CM_ONE);
        default:         w = mk_int(OP_MOV, 1'b0, CM_ZERO);
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/alu_ctl_rowdec.sv
module alu_ctl_rowdec
  import alu_ctl_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter int OPC_W = 4,
  parameter int ROWS  = N_ROWS
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CMD_W-1:0] ucmd_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             trap_i,
  output logic [ROWS-1:0]  hot_o
);
  localparam int IDX_W = $clog2(ROWS);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    case (ucmd_i)
      3'b111: idx = IDX_W'(N_INT_ROWS) + IDX_W'(opcode_i);
      3'b000: idx = (opcode_i == OP_ADD) ? IDX_W'(0) : IDX_W'(1);
      3'b001: idx = opcode_i[2] ? IDX_W'(3) : IDX_W'(2);
      3'b010: idx = opcode_i[0] ? IDX_W'(5) : IDX_W'(4);
      3'b011: idx = opcode_i[2] ? IDX_W'(7) : IDX_W'(6);
      3'b100: idx = opcode_i[2] ? IDX_W'(9) : IDX_W'(8);
      3'b101: idx = trap_i ? IDX_W'(10) : (opcode_i[2] ? IDX_W'(12) : IDX_W'(11));
      3'b110: idx = trap_i ? IDX_W'(13) : IDX_W'(14);
      default: idx = '0;
    endcase
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign hot_o[g] = (idx == IDX_W'(g));
  end

  AST_ONE_ROW: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(hot_o) == 1); // R2
endmodule

// File: rtl/alu_ctl_rom.sv
module alu_ctl_rom
  import alu_ctl_pkg::*;
#(
  parameter int ROWS = N_ROWS
) (
  input  logic [ROWS-1:0] hot_i,
  output ctl_t            word_o
);
  logic [CTL_W-1:0] plane [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_plane
    localparam ctl_t ROW_W = row_word(g);
    assign plane[g] = hot_i[g] ? CTL_W'(ROW_W) : '0;
  end

  always_comb begin
    logic [CTL_W-1:0] acc;
    acc = '0;
    for (int r = 0; r < ROWS; r++) acc = acc | plane[r];
    word_o = ctl_t'(acc);
  end
endmodule

// File: rtl/alu_ctl_carry.sv
module alu_ctl_carry
  import alu_ctl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  cmode_e cmode_i,
  input  logic   carry_i,
  output logic   cin_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) cin_o <= 1'b0;
    else begin
      case (cmode_i)
        CM_PASS: cin_o <= carry_i;
        CM_ONE:  cin_o <= 1'b1;
        default: cin_o <= 1'b0;
      endcase
    end
  end

  AST_CIN_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmode_i == CM_PASS) |=> (cin_o == $past(carry_i))); // R4
endmodule

// File: rtl/alu_ctl.sv
module alu_ctl
  import alu_ctl_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter int OPC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CMD_W-1:0] ucmd_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             trap_i,
  input  logic             carry_i,
  output logic [3:0]       alu_fn_o,
  output logic             chain_en_o,
  output logic             carry_in_o,
  output logic             not_cmp_o,
  output logic             psr_we_o,
  output logic             arith_o
);
  localparam logic [CMD_W-1:0] CMD_DP = '1;

  logic [N_ROWS-1:0] hot;
  ctl_t              word;

  alu_ctl_rowdec #(.CMD_W(CMD_W), .OPC_W(OPC_W), .ROWS(N_ROWS)) u_rowdec (
    .clk_i(clk_i), .rst_i(rst_i), .ucmd_i(ucmd_i), .opcode_i(opcode_i),
    .trap_i(trap_i), .hot_o(hot)
  );

  alu_ctl_rom #(.ROWS(N_ROWS)) u_rom (.hot_i(hot), .word_o(word));

  alu_ctl_carry u_carry (
    .clk_i(clk_i), .rst_i(rst_i), .cmode_i(word.cmode),
    .carry_i(carry_i), .cin_o(carry_in_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      alu_fn_o   <= OP_MOV;
      chain_en_o <= 1'b0;
      not_cmp_o  <= 1'b1;
      psr_we_o   <= 1'b0;
      arith_o    <= 1'b0;
    end else begin
      alu_fn_o   <= word.fn;
      chain_en_o <= word.chain;
      not_cmp_o  <= word.cmp_n;
      psr_we_o   <= word.psr;
      arith_o    <= word.arith;
    end
  end

  AST_DP_FN: assert property (@(posedge clk_i) disable iff (rst_i)
    (ucmd_i == CMD_DP) |=> (alu_fn_o == $past(opcode_i))); // R1
  AST_CMP_CLASS: assert property (@(posedge clk_i) disable iff (rst_i)
    (ucmd_i == CMD_DP && opcode_i[3:2] == 2'b10) |=> !not_cmp_o); // R5
  AST_PSR_INTERNAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (ucmd_i != CMD_DP) |=> !psr_we_o); // R6
  AST_CIN_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !chain_en_o |-> !carry_in_o); // R8
endmodule

// File: tb/alu_ctl_tb.sv
module alu_ctl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, trap, cf;
  logic [2:0] ucmd;
  logic [3:0] opc;
  logic [3:0] fn;
  logic       chain, cin, cmpn, psr, ar;
  int n_chk = 0, n_fail = 0;

  alu_ctl u_dut (
    .clk_i(clk), .rst_i(rst), .ucmd_i(ucmd), .opcode_i(opc), .trap_i(trap),
    .carry_i(cf), .alu_fn_o(fn), .chain_en_o(chain), .carry_in_o(cin),
    .not_cmp_o(cmpn), .psr_we_o(psr), .arith_o(ar)
  );

  localparam logic [8:0] RESET_WORD = 9'b1101_0_0_1_0_0;

  // {ucmd, opcode, trap, carry | fn, chain, cin, not_cmp, psr_we, arith}
  localparam logic [17:0] VEC [16] = '{
    18'b111_0100_0_1_0100_1_0_1_1_1,  // R3 ADD cin 0
    18'b111_0010_0_0_0010_1_1_1_1_1,  // R3 SUB cin 1
    18'b111_0101_0_1_0101_1_1_1_1_1,  // R3 ADC passes 1
    18'b111_0101_0_0_0101_1_0_1_1_1,  // R3 ADC passes 0
    18'b111_1010_0_0_1010_1_1_0_1_1,  // R5 CMP
    18'b111_1000_0_1_1000_0_0_0_1_0,  // R5 R8 TST
    18'b111_1100_1_1_1100_0_0_1_1_0,  // R8 ORR carry ignored
    18'b000_0100_0_1_0100_1_0_1_0_0,  // R12 ADD row
    18'b000_1111_0_1_1101_0_0_1_0_0,  // R12 no-op row
    18'b010_0000_0_0_0100_1_1_1_0_0,  // R9 ADD cin 1
    18'b010_0001_0_1_0011_1_0_1_0_0,  // R9 RSB cin 0
    18'b101_0000_1_0_1101_0_0_1_0_0,  // R9 R10 trapped load
    18'b101_0100_0_0_0100_1_0_1_0_0,  // R9 load ADD
    18'b110_0000_1_0_0011_1_1_1_0_0,  // R9 R10 trapped multiple
    18'b011_0000_0_0_1101_1_1_1_0_0,  // R9 unidentified row
    18'b111_0111_0_1_0111_1_1_1_1_1   // R7 RSC arithmetic
  };

  function automatic logic [8:0] model(logic [2:0] u, logic [3:0] o, logic t, logic c);
    logic [3:0] f; logic en, ci, a;
    if (u == 3'b111) begin
      a  = (o >= 4'd2 && o <= 4'd7) || o == 4'd10 || o == 4'd11;
      en = a;
      if (o == 4'd2 || o == 4'd3 || o == 4'd10) ci = 1'b1;
      else if (o >= 4'd5 && o <= 4'd7) ci = c;
      else ci = 1'b0;
      return {o, en, ci, o[3:2] != 2'b10, 1'b1, a};
    end
    f = 4'b1101; en = 1'b0; ci = 1'b0;
    case (u)
      3'b000: if (o == 4'b0100) begin f = 4'b0100; en = 1'b1; end
      3'b001: begin en = 1'b1; f = o[2] ? 4'b0010 : 4'b0100; ci = o[2]; end
      3'b010: begin en = 1'b1; f = o[0] ? 4'b0011 : 4'b0100; ci = !o[0]; end
      3'b011: begin en = 1'b1; ci = 1'b1; end
      3'b100, 3'b101:
        if (!(u == 3'b101 && t)) begin en = 1'b1; f = o[2] ? 4'b0100 : 4'b0010; ci = !o[2]; end
      default: begin en = 1'b1; f = t ? 4'b0011 : 4'b0100; ci = t; end
    endcase
    return {f, en, ci, 1'b1, 1'b0, 1'b0};
  endfunction

  function automatic logic [8:0] outs();
    return {fn, chain, cin, cmpn, psr, ar};
  endfunction

  task automatic check(string tag, logic [8:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic drive(logic [2:0] u, logic [3:0] o, logic t, logic c);
    @(negedge clk);
    ucmd = u; opc = o; trap = t; cf = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [8:0] ref_w;
    rst = 1'b1; ucmd = 3'b111; opc = 4'b0100; trap = 1'b0; cf = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset word", RESET_WORD);
    rst = 1'b0;

    for (int k = 0; k < 16; k++) begin
      drive(VEC[k][17:15], VEC[k][14:11], VEC[k][10], VEC[k][9]);
      check($sformatf("R1/R3/R5/R6/R7/R8/R9/R12 vector %0d", k), VEC[k][8:0]);
    end

    // R2: every input combination against the model
    for (int i = 0; i < 512; i++) begin
      drive(i[8:6], i[5:2], i[1], i[0]);
      check(i[8:6] == 3'b111 ? "R2 R1 R3 R7" : "R2 R9",
            model(i[8:6], i[5:2], i[1], i[0]));
    end

    // R10: trap has no effect outside micro-commands 101 and 110
    for (int u = 0; u < 8; u++) begin
      if (u == 5 || u == 6) continue;
      for (int o = 0; o < 16; o++) begin
        drive(3'(u), 4'(o), 1'b0, 1'b1);
        ref_w = outs();
        drive(3'(u), 4'(o), 1'b1, 1'b1);
        check("R10 trap ignored", ref_w);
      end
    end

    // R4: carry changing after the sampling edge is not seen
    @(negedge clk);
    ucmd = 3'b111; opc = 4'b0101; trap = 1'b0; cf = 1'b1;
    @(posedge clk); #1 cf = 1'b0;
    @(negedge clk);
    check("R4 late carry change", 9'b0101_1_1_1_1_1);
    @(negedge clk);
    check("R4 new carry taken", 9'b0101_1_0_1_1_1);

    // R11: reset in the middle of traffic
    drive(3'b111, 4'b1010, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset mid-run", RESET_WORD);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule